// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides, for each of several phase-locked loops, whether the loop has settled. It looks at the reference pulse and the feedback pulse that feed a loop's phase/frequency detector, both already synchronous to a fast sample clock. In each comparison cycle it counts the sample clocks between the earlier and the later of the two rising edges. It then judges that phase error against a cycle-count threshold.

The decision has hysteresis. While a loop is unlocked, an error counts as good only when it is below a narrow threshold, and lock is declared only after a run of consecutive good cycles. Once a loop is locked, a much wider threshold applies, and one cycle beyond it, or a feedback edge that never arrives, drops the flag at once. Each loop has its own power-enable. A powered-down loop reports unlocked and forgets any partial run. The per-loop flags are also combined into one flag that is high only when every loop is locked.

Top module: `pll_lock_watch`

## Requirements
- R1: After reset every per-loop lock flag and the combined flag are low.
- R2: An unlocked loop raises its flag after exactly GOOD_RUN consecutive comparison cycles whose error is below NARROW_CYC. GOOD_RUN-1 such cycles are not enough.
- R3: While unlocked, a cycle whose error equals or exceeds NARROW_CYC is bad and sets the run of good cycles back to zero.
- R4: The error is the number of sample clocks from the first rising edge to the second, whichever pulse leads. A feedback-first cycle is judged against the same threshold as a reference-first cycle.
- R5: While locked, an error of up to and including WIDE_CYC keeps the flag high. A single cycle with an error of WIDE_CYC+1 or more clears it.
- R6: A reference edge that is followed by the next reference edge before any feedback edge is a late cycle. A late cycle clears the lock flag and, when the loop is unlocked, clears the run of good cycles.
- R7: When a loop's enable is low, its lock flag is low from the next clock edge and its run of good cycles is cleared. After the enable returns, a full run of GOOD_RUN good cycles is needed again.
- R8: all_lock_o is high exactly when every per-loop lock flag is high.
- R9: Pulses on one loop never change the lock flag of another loop.
- R10: Reference and feedback edges seen in the same sample cycle give an error of zero, which counts as good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all thresholds are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en_i | input | NUM_LOOPS | Per-loop power enable, high = running |
| ref_pulse_i | input | NUM_LOOPS | Per-loop reference pulse, rising edge marks a comparison |
| fb_pulse_i | input | NUM_LOOPS | Per-loop divided feedback pulse |
| loop_lock_o | output | NUM_LOOPS | Registered per-loop lock flag |
| all_lock_o | output | 1 | High when every loop reports lock |

## Verification
The bench builds the block with two loops, NARROW_CYC of 3, WIDE_CYC of 6 and GOOD_RUN of 4. The small thresholds put both boundaries within a single 20-cycle reference period: errors of 2 against 3 for entry, and 6 against 7 for exit. The error counter is then 3 bits wide, so it saturates at exactly WIDE_CYC+1 during a missing feedback edge, and that saturated count is judged as a drop. Two loops are enough to show the combined flag and that the loops do not affect each other.

// File: rtl/lw_pkg.sv
package lw_pkg;

  // State of the per-cycle edge-spacing measurement
  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_REF_LEAD = 2'd1,
    MS_FB_LEAD  = 2'd2
  } meas_state_e;

  // A finished comparison counts toward entering lock
  function automatic logic pair_good(input int unsigned err,
                                     input logic        late,
                                     input int unsigned narrow);
    return !late && (err < narrow);
  endfunction

  // A finished comparison is enough to leave lock
  function automatic logic pair_drop(input int unsigned err,
                                     input logic        late,
                                     input int unsigned wide);
    return late || (err > wide);
  endfunction

endpackage

// File: rtl/lw_edge_meter.sv
module lw_edge_meter
  import lw_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ref_i,
  input  logic             fb_i,
  output logic             pair_done_o,
  output logic [CNT_W-1:0] pair_err_o,
  output logic             pair_late_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ref_q, fb_q;
  logic             ref_rise, fb_rise;
  meas_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign ref_rise = ref_i & ~ref_q;
  assign fb_rise  = fb_i & ~fb_q;
  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_i;
      fb_q  <= fb_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= MS_IDLE;
      cnt_q       <= '0;
      pair_done_o <= 1'b0;
      pair_err_o  <= '0;
      pair_late_o <= 1'b0;
    end else if (!en_i) begin
      st_q        <= MS_IDLE;
      cnt_q       <= '0;
      pair_done_o <= 1'b0;
      pair_late_o <= 1'b0;
    end else begin
      pair_done_o <= 1'b0;
      pair_late_o <= 1'b0;
      unique case (st_q)
        MS_IDLE: begin
          if (ref_rise && fb_rise) begin
            pair_done_o <= 1'b1;
            pair_err_o  <= '0;
          end else if (ref_rise) begin
            st_q  <= MS_REF_LEAD;
            cnt_q <= CNT_ONE;
          end else if (fb_rise) begin
            st_q  <= MS_FB_LEAD;
            cnt_q <= CNT_ONE;
          end
        end
        MS_REF_LEAD: begin
          if (fb_rise) begin
            pair_done_o <= 1'b1;
            pair_err_o  <= cnt_q;
            if (ref_rise) cnt_q <= CNT_ONE;
            else          st_q  <= MS_IDLE;
          end else if (ref_rise) begin
            // next reference came first: feedback is missing
            pair_done_o <= 1'b1;
            pair_late_o <= 1'b1;
            pair_err_o  <= cnt_q;
            cnt_q       <= CNT_ONE;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        MS_FB_LEAD: begin
          if (ref_rise) begin
            pair_done_o <= 1'b1;
            pair_err_o  <= cnt_q;
            st_q        <= MS_IDLE;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        default: st_q <= MS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lw_lock_filter.sv
module lw_lock_filter
  import lw_pkg::*;
#(
  parameter int unsigned NARROW_CYC = 4,
  parameter int unsigned WIDE_CYC   = 8,
  parameter int unsigned GOOD_RUN   = 4,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned RUN_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] err_i,
  input  logic             late_i,
  output logic             lock_o,
  output logic [RUN_W-1:0] run_o
);

  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(GOOD_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

  logic good_w, drop_w;

  assign good_w = pair_good(32'(err_i), late_i, NARROW_CYC);
  assign drop_w = pair_drop(32'(err_i), late_i, WIDE_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      lock_o <= 1'b0;
      run_o  <= '0;
    end else if (done_i) begin
      if (!lock_o) begin
        if (good_w) begin
          if (run_o == LAST_RUN) begin
            lock_o <= 1'b1;
            run_o  <= '0;
          end else begin
            run_o <= run_o + RUN_ONE;
          end
        end else begin
          run_o <= '0;
        end
      end else if (drop_w) begin
        lock_o <= 1'b0;
        run_o  <= '0;
      end
    end
  end

endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch
  import lw_pkg::*;
#(
  parameter int unsigned NUM_LOOPS  = 2,
  parameter int unsigned NARROW_CYC = 4,
  parameter int unsigned WIDE_CYC   = 2 * NARROW_CYC,
  parameter int unsigned GOOD_RUN   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LOOPS-1:0] loop_en_i,
  input  logic [NUM_LOOPS-1:0] ref_pulse_i,
  input  logic [NUM_LOOPS-1:0] fb_pulse_i,
  output logic [NUM_LOOPS-1:0] loop_lock_o,
  output logic                 all_lock_o
);

  localparam int unsigned CNT_W = $clog2(WIDE_CYC + 2);
  localparam int unsigned RUN_W = (GOOD_RUN < 2) ? 1 : $clog2(GOOD_RUN);

  // Named internal events, observed by the bound checker
  logic [NUM_LOOPS-1:0]            meas_done_w;
  logic [NUM_LOOPS-1:0]            meas_late_w;
  logic [NUM_LOOPS-1:0][CNT_W-1:0] meas_err_w;
  logic [NUM_LOOPS-1:0][RUN_W-1:0] run_w;
  logic [NUM_LOOPS-1:0]            lock_w;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    lw_edge_meter #(.CNT_W(CNT_W)) meter_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (loop_en_i[g]),
      .ref_i       (ref_pulse_i[g]),
      .fb_i        (fb_pulse_i[g]),
      .pair_done_o (meas_done_w[g]),
      .pair_err_o  (meas_err_w[g]),
      .pair_late_o (meas_late_w[g])
    );

    lw_lock_filter #(
      .NARROW_CYC (NARROW_CYC),
      .WIDE_CYC   (WIDE_CYC),
      .GOOD_RUN   (GOOD_RUN),
      .CNT_W      (CNT_W),
      .RUN_W      (RUN_W)
    ) filter_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (loop_en_i[g]),
      .done_i (meas_done_w[g]),
      .err_i  (meas_err_w[g]),
      .late_i (meas_late_w[g]),
      .lock_o (lock_w[g]),
      .run_o  (run_w[g])
    );
  end

  assign loop_lock_o = lock_w;
  assign all_lock_o  = &lock_w;

endmodule

// File: rtl/pll_lock_watch_chk.sv
module pll_lock_watch_chk #(
  parameter int unsigned NUM_LOOPS  = 2,
  parameter int unsigned NARROW_CYC = 4,
  parameter int unsigned WIDE_CYC   = 8,
  parameter int unsigned GOOD_RUN   = 4,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned RUN_W      = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_LOOPS-1:0]            loop_en,
  input logic [NUM_LOOPS-1:0]            lock,
  input logic [NUM_LOOPS-1:0]            meas_done,
  input logic [NUM_LOOPS-1:0]            meas_late,
  input logic [NUM_LOOPS-1:0][CNT_W-1:0] meas_err,
  input logic [NUM_LOOPS-1:0][RUN_W-1:0] run
);

  localparam logic [CNT_W-1:0] NARROW_V = CNT_W'(NARROW_CYC);
  localparam logic [CNT_W-1:0] WIDE_V   = CNT_W'(WIDE_CYC);
  localparam logic [RUN_W-1:0] RUN_LIM  = RUN_W'(GOOD_RUN - 1);

  for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_chk
    AST_PWRDN_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en[i] |=> !lock[i]); // R7

    AST_ENTRY_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock[i]) |-> $past(meas_done[i] && !meas_late[i] && (meas_err[i] < NARROW_V))); // R2

    AST_EXIT_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock[i]) |-> $past(!loop_en[i] || (meas_done[i] && (meas_late[i] || (meas_err[i] > WIDE_V))))); // R5

    AST_NARROW_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_done[i] && !lock[i] && (meas_late[i] || (meas_err[i] >= NARROW_V)))
        |=> (run[i] == '0) && !lock[i]); // R3

    AST_LATE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_done[i] && meas_late[i]) |=> !lock[i]); // R6

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      run[i] <= RUN_LIM); // R2
  end

endmodule

bind pll_lock_watch pll_lock_watch_chk #(
  .NUM_LOOPS  (NUM_LOOPS),
  .NARROW_CYC (NARROW_CYC),
  .WIDE_CYC   (WIDE_CYC),
  .GOOD_RUN   (GOOD_RUN),
  .CNT_W      (CNT_W),
  .RUN_W      (RUN_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .loop_en   (loop_en_i),
  .lock      (lock_w),
  .meas_done (meas_done_w),
  .meas_late (meas_late_w),
  .meas_err  (meas_err_w),
  .run       (run_w)
);

// File: tb/pll_lock_watch_tb_top.sv
module pll_lock_watch_tb_top;

  localparam int NL     = 2;
  localparam int NARROW = 3;
  localparam int WIDE   = 6;
  localparam int RUNLEN = 4;
  localparam int PERIOD = 20;
  localparam int BASE   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] loop_en = '0;
  logic [NL-1:0] ref_pulse = '0;
  logic [NL-1:0] fb_pulse = '0;
  logic [NL-1:0] loop_lock;
  logic          all_lock;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pll_lock_watch #(
    .NUM_LOOPS(NL), .NARROW_CYC(NARROW), .WIDE_CYC(WIDE), .GOOD_RUN(RUNLEN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .loop_en_i(loop_en),
    .ref_pulse_i(ref_pulse), .fb_pulse_i(fb_pulse),
    .loop_lock_o(loop_lock), .all_lock_o(all_lock)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // One reference period; feedback edge at reference + delta (negative = feedback leads)
  task automatic frame(input int lp, input int delta, input bit miss);
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk);
      ref_pulse[lp] = (c == BASE);
      fb_pulse[lp]  = !miss && (c == BASE + delta);
    end
    @(negedge clk);
    ref_pulse[lp] = 1'b0;
    fb_pulse[lp]  = 1'b0;
  endtask

  task automatic frames(input int lp, input int delta, input int n);
    for (int k = 0; k < n; k++) frame(lp, delta, 1'b0);
  endtask

  task automatic pdown(input int lp);
    @(negedge clk); loop_en[lp] = 1'b0;
    @(negedge clk); loop_en[lp] = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 loop0 lock after reset", loop_lock[0], 1'b0);
    chk("R1 loop1 lock after reset", loop_lock[1], 1'b0);
    chk("R1 all_lock after reset", all_lock, 1'b0);
  endtask

  task automatic t_entry_run();
    pdown(0);
    frames(0, 1, RUNLEN - 1);
    chk("R2 unlocked after GOOD_RUN-1 good", loop_lock[0], 1'b0);
    frame(0, 1, 1'b0);
    chk("R2 locked after GOOD_RUN good", loop_lock[0], 1'b1);
  endtask

  task automatic t_narrow_edge();
    pdown(0);
    frames(0, 2, 3);
    frame(0, 3, 1'b0);
    chk("R3 error==NARROW not good", loop_lock[0], 1'b0);
    frames(0, 2, 3);
    chk("R3 run restarted from zero", loop_lock[0], 1'b0);
    frame(0, 2, 1'b0);
    chk("R3 lock after fresh run", loop_lock[0], 1'b1);
  endtask

  task automatic t_fb_first();
    pdown(0);
    frames(0, -2, 3);
    frame(0, -3, 1'b0);
    chk("R4 fb-first error 3 is bad", loop_lock[0], 1'b0);
    frames(0, -2, 4);
    chk("R4 fb-first error 2 locks", loop_lock[0], 1'b1);
  endtask

  task automatic t_wide_exit();
    pdown(0);
    frames(0, 1, RUNLEN);
    frame(0, WIDE, 1'b0);
    chk("R5 error==WIDE keeps lock", loop_lock[0], 1'b1);
    frame(0, 4, 1'b0);
    chk("R5 mid error keeps lock", loop_lock[0], 1'b1);
    frame(0, -WIDE, 1'b0);
    chk("R5 fb-first error==WIDE keeps lock", loop_lock[0], 1'b1);
    frame(0, WIDE + 1, 1'b0);
    chk("R5 error WIDE+1 drops lock", loop_lock[0], 1'b0);
    frames(0, 1, RUNLEN - 1);
    chk("R5 relock needs full run", loop_lock[0], 1'b0);
  endtask

  task automatic t_missing_fb();
    pdown(0);
    frames(0, 1, RUNLEN);
    chk("R6 locked before missing fb", loop_lock[0], 1'b1);
    frame(0, 0, 1'b1);
    frame(0, 1, 1'b0);
    chk("R6 missing fb drops lock", loop_lock[0], 1'b0);
    frames(0, 1, RUNLEN - 1);
    chk("R6 relock after late + run", loop_lock[0], 1'b1);
    pdown(0);
    frames(0, 1, 2);
    frame(0, 0, 1'b1);
    frames(0, 1, 3);
    chk("R6 late clears unlocked run", loop_lock[0], 1'b0);
  endtask

  task automatic t_powerdown();
    pdown(0);
    frames(0, 1, RUNLEN);
    @(negedge clk); loop_en[0] = 1'b0;
    @(negedge clk);
    chk("R7 lock low one clock after disable", loop_lock[0], 1'b0);
    frame(0, 1, 1'b0);
    chk("R7 pulses ignored while disabled", loop_lock[0], 1'b0);
    loop_en[0] = 1'b1;
    frames(0, 1, RUNLEN - 1);
    chk("R7 full run needed after enable", loop_lock[0], 1'b0);
    pdown(0);
    frame(0, 1, 1'b0);
    chk("R7 run cleared by power-down", loop_lock[0], 1'b0);
    frame(0, 1, 1'b0);
  endtask

  task automatic t_same_cycle();
    pdown(0);
    frames(0, 0, RUNLEN);
    chk("R10 coincident edges lock", loop_lock[0], 1'b1);
  endtask

  task automatic t_two_loops();
    pdown(0);
    pdown(1);
    frames(0, 1, RUNLEN);
    chk("R8 all_lock low with one loop", all_lock, 1'b0);
    chk("R9 loop1 unaffected by loop0", loop_lock[1], 1'b0);
    frames(1, -1, RUNLEN);
    chk("R8 all_lock high with both", all_lock, 1'b1);
    chk("R9 loop0 kept during loop1 traffic", loop_lock[0], 1'b1);
    frame(1, WIDE + 1, 1'b0);
    chk("R9 loop1 dropped", loop_lock[1], 1'b0);
    chk("R9 loop0 unaffected by loop1 drop", loop_lock[0], 1'b1);
    chk("R8 all_lock low after loop1 drop", all_lock, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    loop_en = '1;
    t_entry_run();
    t_narrow_edge();
    t_fb_first();
    t_wide_exit();
    t_missing_fb();
    t_powerdown();
    t_same_cycle();
    t_two_loops();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule